// File: doc/BRIEF.md
# Miss-Time Word Usage Predictor

This block holds a small, untagged, direct-mapped table of word-usage bitmaps. When the data cache misses, it is handed the address of the instruction that missed and the position of the missing 8-byte word inside its spatial group. One cycle later it returns a bitmap that says which words of the group are expected to be touched. The cache can use that bitmap to fetch only the marked sub-blocks of one line, or to prefetch the marked lines of a group of several consecutive lines.

The table entry is not picked by the data address. It is picked by hashing the instruction address with the word offset of the miss inside its 64-byte line. The cache keeps the returned index with the line while the line is resident, and it gathers the words that are really used. When the line is evicted, the cache writes that gathered bitmap back into the same entry in a single cycle. By default the table has 256 entries of 40 bits. That is five lines of eight words each, about 1.25 Kbyte in total. Reset fills every entry with ones, so an untrained prediction asks for everything.

Top module: `spp_predictor`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pred_valid` is 0. Once reset is over, every table entry reads as all ones until it is overwritten.
- R2: The table index equals `miss_pc[9:2]` XOR (`miss_word[2:0]` shifted left by 5). `miss_pc[1:0]` plays no part. The index used is reported on `pred_index` together with the prediction.
- R3: `pred_valid` is high in exactly the cycle after a cycle with `miss_valid` high, and low in every other cycle.
- R4: `pred_pattern` equals the selected entry ORed with a single one at bit position `miss_word`. Bit k stands for 8-byte word k of the group, and bit 0 is the lowest word of the first line.
- R5: When `evict_valid` is high, the entry at `evict_index` is overwritten with `evict_usage`. A miss that selects that entry in any later cycle sees the new bitmap.
- R6: If a miss and an eviction select the same entry in the same cycle, the miss returns the contents from before the write.
- R7: The table has no tags. Two instruction addresses that map to the same index share one entry, whatever their upper bits are.
- R8: `pred_pattern` and `pred_index` keep their last values in cycles that follow a cycle without a miss.
- R9: An eviction that comes without a miss produces no prediction, so `pred_valid` stays 0 and the outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A data cache miss asks for a prediction |
| miss_pc | input | 32 | Address of the missing load or store instruction |
| miss_word | input | 6 | Position of the missing 8-byte word within the group (0 to 39) |
| evict_valid | input | 1 | A line is evicted and its usage is written back |
| evict_index | input | 8 | Table index that was kept with the evicted line |
| evict_usage | input | 40 | Words actually touched while the line was resident |
| pred_valid | output | 1 | Prediction is valid in this cycle |
| pred_index | output | 8 | Index of the entry used for the prediction |
| pred_pattern | output | 40 | Predicted word-usage bitmap |

## Verification
The assertions take for granted that `miss_word` is always below the pattern width whenever `miss_valid` is high. They also take for granted that the eviction inputs come from a previously returned index, so no value outside the table is ever presented. The stimulus draws word positions only from 0 to 39 and draws indices from the 8-bit range. It narrows the instruction addresses so that aliasing, back-to-back hits on one entry and same-cycle lookup and write collisions all happen often. A behavioural array in the bench is compared against the outputs on every cycle.

// File: rtl/spp_pkg.sv
package spp_pkg;

    localparam int SPP_PC_W        = 32;
    localparam int SPP_IDX_W       = 8;
    localparam int SPP_LINE_WORDS  = 8;
    localparam int SPP_GROUP_LINES = 5;

    // One-hot mask for a word position inside a pattern of up to 64 bits
    function automatic logic [63:0] spp_word_bit(input int unsigned pos);
        logic [63:0] m;
        m = 64'd1 << pos;
        return m;
    endfunction

endpackage

// File: rtl/spp_index_hash.sv
module spp_index_hash #(
    parameter int PC_W   = spp_pkg::SPP_PC_W,
    parameter int IDX_W  = spp_pkg::SPP_IDX_W,
    parameter int OFF_W  = 3,
    parameter int WORD_W = 6
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  idx
);
    localparam int PAD_W = IDX_W - OFF_W;

    logic [IDX_W-1:0] pc_part;
    logic [IDX_W-1:0] off_part;

    always_comb begin
        pc_part  = pc[IDX_W+1:2];
        off_part = {word[OFF_W-1:0], {PAD_W{1'b0}}};
        idx      = pc_part ^ off_part;
    end
endmodule

// File: rtl/spp_pattern_store.sv
module spp_pattern_store #(
    parameter int IDX_W = spp_pkg::SPP_IDX_W,
    parameter int PAT_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PAT_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PAT_W-1:0] wr_data
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [PAT_W-1:0] table_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                table_q[i] <= '1;
            end
        end else if (wr_en) begin
            table_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = table_q[rd_idx];
endmodule

// File: rtl/spp_predict_reg.sv
module spp_predict_reg #(
    parameter int IDX_W  = spp_pkg::SPP_IDX_W,
    parameter int PAT_W  = 40,
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lookup_valid,
    input  logic [IDX_W-1:0]  lookup_idx,
    input  logic [WORD_W-1:0] lookup_word,
    input  logic [PAT_W-1:0]  entry,
    output logic              pred_valid,
    output logic [IDX_W-1:0]  pred_index,
    output logic [PAT_W-1:0]  pred_pattern
);
    logic [63:0]      wide_bit;
    logic [PAT_W-1:0] miss_bit;

    always_comb begin
        wide_bit = spp_pkg::spp_word_bit(32'(lookup_word));
        miss_bit = wide_bit[PAT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_valid   <= 1'b0;
            pred_index   <= '0;
            pred_pattern <= '0;
        end else begin
            pred_valid <= lookup_valid;
            if (lookup_valid) begin
                pred_index   <= lookup_idx;
                pred_pattern <= entry | miss_bit;
            end
        end
    end
endmodule

// File: rtl/spp_predictor.sv
module spp_predictor #(
    parameter int PC_W        = spp_pkg::SPP_PC_W,
    parameter int IDX_W       = spp_pkg::SPP_IDX_W,
    parameter int LINE_WORDS  = spp_pkg::SPP_LINE_WORDS,
    parameter int GROUP_LINES = spp_pkg::SPP_GROUP_LINES,
    localparam int PAT_W      = LINE_WORDS * GROUP_LINES,
    localparam int WORD_W     = $clog2(PAT_W),
    localparam int OFF_W      = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [PC_W-1:0]   miss_pc,
    input  logic [WORD_W-1:0] miss_word,
    input  logic              evict_valid,
    input  logic [IDX_W-1:0]  evict_index,
    input  logic [PAT_W-1:0]  evict_usage,
    output logic              pred_valid,
    output logic [IDX_W-1:0]  pred_index,
    output logic [PAT_W-1:0]  pred_pattern
);
    logic [IDX_W-1:0] lk_idx;
    logic [PAT_W-1:0] lk_entry;

    spp_index_hash #(
        .PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W)
    ) i_hash (
        .pc(miss_pc), .word(miss_word), .idx(lk_idx)
    );

    spp_pattern_store #(
        .IDX_W(IDX_W), .PAT_W(PAT_W)
    ) i_store (
        .clk(clk), .rst(rst),
        .rd_idx(lk_idx), .rd_data(lk_entry),
        .wr_en(evict_valid), .wr_idx(evict_index), .wr_data(evict_usage)
    );

    spp_predict_reg #(
        .IDX_W(IDX_W), .PAT_W(PAT_W), .WORD_W(WORD_W)
    ) i_out (
        .clk(clk), .rst(rst),
        .lookup_valid(miss_valid), .lookup_idx(lk_idx),
        .lookup_word(miss_word), .entry(lk_entry),
        .pred_valid(pred_valid), .pred_index(pred_index),
        .pred_pattern(pred_pattern)
    );
endmodule

// File: rtl/spp_predictor_chk.sv
module spp_predictor_chk #(
    parameter int IDX_W  = 8,
    parameter int PAT_W  = 40,
    parameter int WORD_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic [WORD_W-1:0] miss_word,
    input logic              pred_valid,
    input logic [IDX_W-1:0]  pred_index,
    input logic [PAT_W-1:0]  pred_pattern
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pred_valid);                                   // R1

    AST_MISS_LATENCY: assert property (@(posedge clk) disable iff (rst)
        miss_valid |=> pred_valid);                                    // R3

    AST_NO_SPURIOUS_PRED: assert property (@(posedge clk) disable iff (rst)
        !miss_valid |=> !pred_valid);                                  // R9

    AST_MISS_WORD_SET: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> (((pred_pattern >> $past(miss_word)) & PAT_W'(1)) != '0)); // R4

    AST_HOLD_PATTERN: assert property (@(posedge clk) disable iff (rst)
        !miss_valid |=> ($stable(pred_pattern) && $stable(pred_index)));  // R8
endmodule

bind spp_predictor spp_predictor_chk #(
    .IDX_W(IDX_W), .PAT_W(PAT_W), .WORD_W(WORD_W)
) i_chk (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_word(miss_word),
    .pred_valid(pred_valid), .pred_index(pred_index), .pred_pattern(pred_pattern)
);

// File: tb/test_spp_predictor.sv
module test_spp_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_pc = '0;
    logic [5:0]  miss_word = '0;
    logic        evict_valid = 1'b0;
    logic [7:0]  evict_index = '0;
    logic [39:0] evict_usage = '0;
    logic        pred_valid;
    logic [7:0]  pred_index;
    logic [39:0] pred_pattern;

    always #4 clk = ~clk;

    spp_predictor i_spp_predictor (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_pc(miss_pc),
        .miss_word(miss_word), .evict_valid(evict_valid),
        .evict_index(evict_index), .evict_usage(evict_usage),
        .pred_valid(pred_valid), .pred_index(pred_index),
        .pred_pattern(pred_pattern)
    );

    logic [39:0] model [256];
    logic        exp_valid = 1'b0;
    logic [7:0]  exp_idx = '0;
    logic [39:0] exp_pat = '0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    function automatic logic [7:0] ref_index(logic [31:0] pc, int w);
        int unsigned v;
        v = ((pc >> 2) & 32'hFF) ^ ((w % 8) * 32);
        return v[7:0];
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        miss_valid = 1'b0;
        evict_valid = 1'b0;
        for (int i = 0; i < 256; i++) model[i] = '1;
        exp_valid = 1'b0; exp_idx = '0; exp_pat = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1 valid low in reset", 64'(pred_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid low after reset", 64'(pred_valid), 64'd0);
    endtask

    // Drives one cycle at a falling edge and compares at the next one
    task automatic step(bit mv, logic [31:0] pc, int w, bit ev, logic [7:0] ei,
                        logic [39:0] eu, string tag);
        miss_valid  = mv;
        miss_pc     = pc;
        miss_word   = 6'(w);
        evict_valid = ev;
        evict_index = ei;
        evict_usage = eu;
        exp_valid   = mv;
        if (mv) begin
            exp_idx = ref_index(pc, w);
            exp_pat = model[exp_idx] | (40'd1 << w);
        end
        if (ev) model[ei] = eu;
        @(negedge clk);
        check("R3 pred_valid", 64'(pred_valid), 64'(exp_valid));
        check({tag, " pattern"}, 64'(pred_pattern), 64'(exp_pat));
        check("R2 index", 64'(pred_index), 64'(exp_idx));
    endtask

    task automatic idle();
        step(1'b0, 32'h0, 0, 1'b0, 8'h0, 40'h0, "R8");
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: untrained entries read as all ones
        step(1'b1, 32'h0000_1000, 3, 1'b0, 8'h0, 40'h0, "R1");
        step(1'b1, 32'h0000_2F7C, 39, 1'b0, 8'h0, 40'h0, "R1");
        idle();

        // R5 and R4: write, then read; the miss word is forced in
        step(1'b0, 32'h0, 0, 1'b1, ref_index(32'h0000_0040, 2), 40'h00_0000_00F0, "R9");
        step(1'b1, 32'h0000_0040, 2, 1'b0, 8'h0, 40'h0, "R4 R5");
        step(1'b1, 32'h0000_0040, 2, 1'b0, 8'h0, 40'h0, "R5 repeat");

        // R2: word offset bits and low PC bits
        step(1'b1, 32'h0000_0043, 10, 1'b0, 8'h0, 40'h0, "R2");

        // R6: lookup and write to the same entry together
        step(1'b1, 32'h0000_0080, 1, 1'b1, ref_index(32'h0000_0080, 1), 40'hAA_0000_0000, "R6 old");
        step(1'b1, 32'h0000_0080, 9, 1'b0, 8'h0, 40'h0, "R6 new");

        // R7: upper PC bits alias onto one entry
        step(1'b0, 32'h0, 0, 1'b1, ref_index(32'h0000_0100, 4), 40'h00_0000_0001, "R9");
        step(1'b1, 32'hABCD_0500, 4, 1'b0, 8'h0, 40'h0, "R7");
        step(1'b1, 32'h0000_0100, 12, 1'b0, 8'h0, 40'h0, "R7 alias");

        // R8 and R9: outputs hold with no miss, even with writes
        idle();
        step(1'b0, 32'h0, 0, 1'b1, 8'h11, 40'h12_3456_789A, "R9");
        idle();

        // Random traffic over a narrow address range
        for (int n = 0; n < 3000; n++) begin
            bit          mv;
            bit          ev;
            logic [31:0] pc;
            int          w;
            logic [7:0]  ei;
            logic [39:0] eu;
            mv = ($urandom % 3) != 0;
            ev = ($urandom % 2) != 0;
            pc = $urandom & 32'h0000_F0FF;
            w  = int'($urandom % 40);
            ei = ($urandom % 2 == 0) ? ref_index(pc, w) : 8'($urandom % 16);
            eu = {8'($urandom), $urandom};
            step(mv, pc, w, ev, ei, eu, "R4 R5 random");
        end

        // R1: a new reset restores all ones
        do_reset();
        step(1'b1, 32'h0000_0040, 2, 1'b0, 8'h0, 40'h0, "R1 after rerun");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule